// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block holds two registers of a serial port's modem interface. The control register is written by the host. Two of its bits drive the active-low data-terminal-ready and request-to-send pins. The status register is read by the host. It shows the true state of the active-low clear-to-send and data-set-ready inputs. It also shows one sticky change flag per input.

Each input pin first passes through a chain of synchronising flops. Each change flag is then kept by a small two-state machine. STEADY means no change has been seen since the last status read. PENDING means a change has been seen.
- Transition *seen-change* (STEADY to PENDING) fires on any edge of the synchronised input.
- Transition *cleared* (PENDING to STEADY) fires on a status-register read strobe when no new edge arrives in the same cycle.
- Transition *re-armed* (PENDING to PENDING) fires when a read strobe and a fresh edge coincide, so that edge is not lost.

A modem-status interrupt request is raised while any flag is set and the host has enabled it. Master reset clears the control register, which makes both output pins inactive (high).

Top module: `mdm_ctl_stat`

## Requirements
- R1: While master reset `rst` is high and on the cycle after it, `dtr_n` and `rts_n` are 1 and `irq` is 0. With `cts_n` and `dsr_n` held at 1, the status register reads 0x00 after reset.
- R2: Writing the control register (`reg_sel`=0, `wr_en`=1) with bit 0 set to 1 drives `dtr_n` to 0 from the next cycle. Writing bit 0 as 0 drives `dtr_n` to 1. A read of the control register returns the two stored bits in bits 1:0 and 0 in all other bits.
- R3: Writing control bit 1 as 1 drives `rts_n` to 0 from the next cycle. Writing it as 0 drives `rts_n` to 1.
- R4: Status bit 4 reads the complement of `cts_n`. Status bit 5 reads the complement of `dsr_n`. Each is visible SYNC_STAGES cycles after the pin changes.
- R5: Status bit 0 becomes 1 one cycle after bit 4 changes, for a change in either direction. It stays 1 until a status read clears it.
- R6: Status bit 1 behaves in the same way for changes of the data-set-ready input.
- R7: A cycle with `rd_en`=1 and `reg_sel`=1 clears bits 0 and 1 from the next cycle. A read of the control register leaves them unchanged.
- R8: When an input edge reaches the flag logic in the same cycle as a clearing status read, the matching flag is 1 after that cycle.
- R9: `irq` equals `irq_en` AND (status bit 0 OR status bit 1).
- R10: A write with `reg_sel`=1 changes neither the control register nor any status bit.
- R11: Status bits 2, 3, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| reg_sel | input | 1 | Register select: 0 = control, 1 = status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (a status read clears the change flags) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register (combinational) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| irq_en | input | 1 | Enable for the modem-status interrupt |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. This sets the pin-to-flag latency at three cycles, so a pin edge can be placed exactly on the cycle of a clearing read. That placement exercises the *re-armed* transition, which is the hardest case of the flag machine. It sits alongside the *seen-change* transition in both directions and the *cleared* transition. The control-write vectors also cover writes with the upper data bits set and writes aimed at the status register.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    typedef enum logic {
        DLT_STEADY  = 1'b0,
        DLT_PENDING = 1'b1
    } dlt_state_t;

    typedef enum logic {
        SEL_CTL  = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_t;

    localparam int unsigned CTL_BITS = 2;
    localparam int unsigned CT_DTR   = 0;
    localparam int unsigned CT_RTS   = 1;

    localparam int unsigned N_PINS   = 2;
    localparam int unsigned PIN_CTS  = 0;
    localparam int unsigned PIN_DSR  = 1;

    localparam int unsigned ST_DCTS  = 0;
    localparam int unsigned ST_DDSR  = 1;
    localparam int unsigned ST_CTS   = 4;
    localparam int unsigned ST_DSR   = 5;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mdm_delta_fsm.sv
module mdm_delta_fsm
    import mdm_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic clr,
    output logic delta
);

    dlt_state_t state_q, state_d;
    logic       prev_q;
    logic       chg;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= level;
    end

    assign chg = level ^ prev_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLT_STEADY:  if (chg)              state_d = DLT_PENDING;
            DLT_PENDING: if (clr && !chg)      state_d = DLT_STEADY;
            default:                           state_d = DLT_STEADY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= DLT_STEADY;
        else     state_q <= state_d;
    end

    // Output
    always_comb begin
        delta = (state_q == DLT_PENDING);
    end

    assert_set_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
        chg |=> delta);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (delta && !clr) |=> delta);

    assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !chg) |=> !delta);

    assert_keep_on_collision_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && chg) |=> delta);

endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
    import mdm_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              irq_en,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              irq
);

    reg_sel_t            sel;
    logic                wr_ctl;
    logic                clr_dlt;
    logic [CTL_BITS-1:0] ctl_q;
    logic [N_PINS-1:0]   pin_n;
    logic [N_PINS-1:0]   pin_sync_n;
    logic [N_PINS-1:0]   delta;

    assign sel     = reg_sel_t'(reg_sel);
    assign wr_ctl  = wr_en && (sel == SEL_CTL);
    assign clr_dlt = rd_en && (sel == SEL_STAT);

    // Control register
    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wdata[CTL_BITS-1:0];
    end

    assign dtr_n = ~ctl_q[CT_DTR];
    assign rts_n = ~ctl_q[CT_RTS];

    // Input pins: synchroniser and change tracker per pin
    assign pin_n[PIN_CTS] = cts_n;
    assign pin_n[PIN_DSR] = dsr_n;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            mdm_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (pin_n[i]),
                .q   (pin_sync_n[i])
            );

            mdm_delta_fsm #(
                .RST_VAL (1'b1)
            ) u_dlt (
                .clk   (clk),
                .rst   (rst),
                .level (pin_sync_n[i]),
                .clr   (clr_dlt),
                .delta (delta[i])
            );
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTL: rdata[CTL_BITS-1:0] = ctl_q;
            SEL_STAT: begin
                rdata[ST_DCTS] = delta[PIN_CTS];
                rdata[ST_DDSR] = delta[PIN_DSR];
                rdata[ST_CTS]  = ~pin_sync_n[PIN_CTS];
                rdata[ST_DSR]  = ~pin_sync_n[PIN_DSR];
            end
            default: rdata = '0;
        endcase
    end

    assign irq = irq_en && (|delta);

    assert_reset_pins_R1: assert property (@(posedge clk)
        rst |=> (dtr_n && rts_n && !delta[0] && !delta[1]));

    assert_dtr_follows_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> (dtr_n == !$past(wdata[CT_DTR])));

    assert_rts_follows_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> (rts_n == !$past(wdata[CT_RTS])));

    assert_stat_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_STAT) |=> $stable(ctl_q));

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && delta != '0));

endmodule

// File: tb/tb_mdm_ctl_stat.sv
module tb_mdm_ctl_stat;

    localparam int DW  = 8;
    localparam int SYN = 2;
    localparam int LAT = SYN + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_sel, wr_en, rd_en, irq_en;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          cts_n, dsr_n;
    logic          dtr_n, rts_n, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mdm_ctl_stat #(.DATA_W(DW), .SYNC_STAGES(SYN)) dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .irq_en(irq_en), .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
    );

    typedef struct packed {
        logic          sel;
        logic [DW-1:0] wd;
        logic          e_dtr_n;
        logic          e_rts_n;
        logic [DW-1:0] e_rd;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{sel:1'b0, wd:8'h01, e_dtr_n:1'b0, e_rts_n:1'b1, e_rd:8'h01},  // R2
        '{sel:1'b0, wd:8'h02, e_dtr_n:1'b1, e_rts_n:1'b0, e_rd:8'h02},  // R3
        '{sel:1'b0, wd:8'hFF, e_dtr_n:1'b0, e_rts_n:1'b0, e_rd:8'h03},  // R2 upper bits
        '{sel:1'b1, wd:8'h00, e_dtr_n:1'b0, e_rts_n:1'b0, e_rd:8'h03},  // R10
        '{sel:1'b0, wd:8'hFC, e_dtr_n:1'b1, e_rts_n:1'b1, e_rd:8'h00},  // R2 R3
        '{sel:1'b0, wd:8'h03, e_dtr_n:1'b0, e_rts_n:1'b0, e_rd:8'h03}   // R2 R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic s, input logic [DW-1:0] d);
        @(negedge clk);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic s, output logic [DW-1:0] d);
        reg_sel = s; rd_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic read_stat_clear();
        @(negedge clk);
        reg_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] r;
        rst = 1'b1; reg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        irq_en = 1'b0; wdata = '0; cts_n = 1'b1; dsr_n = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1 reset state
        chk("R1 dtr_n", dtr_n, 1'b1);
        chk("R1 rts_n", rts_n, 1'b1);
        chk("R1 irq", irq, 1'b0);
        peek(1'b1, r);
        chk("R1 status", r, 8'h00);

        // Control-register vectors
        for (int i = 0; i < 6; i++) begin
            write_reg(VEC[i].sel, VEC[i].wd);
            #1;
            chk("R2 dtr_n vector", dtr_n, VEC[i].e_dtr_n);
            chk("R3 rts_n vector", rts_n, VEC[i].e_rts_n);
            peek(1'b0, r);
            chk("R2 ctl readback", r, VEC[i].e_rd);
            peek(1'b1, r);
            chk("R10 status unaffected", r, 8'h00);
        end

        // R1 master reset forces pins inactive
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 dtr_n after reset", dtr_n, 1'b1);
        chk("R1 rts_n after reset", rts_n, 1'b1);
        rst = 1'b0;

        // R4/R5 clear-to-send goes active
        @(negedge clk); cts_n = 1'b0;
        wait_n(LAT);
        peek(1'b1, r);
        chk("R4 R5 status after cts low", r, 8'h11);
        chk("R11 unused bits", r & 8'hCC, 8'h00);
        #1 chk("R9 irq disabled", irq, 1'b0);
        irq_en = 1'b1;
        #1 chk("R9 irq enabled", irq, 1'b1);

        // R7 clearing read
        read_stat_clear();
        peek(1'b1, r);
        chk("R7 status after clear", r, 8'h10);
        #1 chk("R9 irq after clear", irq, 1'b0);

        // R6 data-set-ready goes active
        @(negedge clk); dsr_n = 1'b0;
        wait_n(LAT);
        peek(1'b1, r);
        chk("R6 status after dsr low", r, 8'h32);

        // R7 control read does not clear
        @(negedge clk); reg_sel = 1'b0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek(1'b1, r);
        chk("R7 ctl read keeps flags", r, 8'h32);
        read_stat_clear();
        peek(1'b1, r);
        chk("R7 cleared", r, 8'h30);

        // R5 change in the other direction, then R8 collision
        @(negedge clk); cts_n = 1'b1;
        wait_n(LAT);
        peek(1'b1, r);
        chk("R5 rising-pin change", r, 8'h21);
        @(negedge clk); cts_n = 1'b0;
        wait_n(SYN - 1);
        @(negedge clk); reg_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek(1'b1, r);
        chk("R8 flag kept on collision", r, 8'h31);
        read_stat_clear();
        peek(1'b1, r);
        chk("R8 later clear", r, 8'h30);

        // R10 write to status address does not touch flags
        @(negedge clk); dsr_n = 1'b1;
        wait_n(LAT);
        write_reg(1'b1, 8'h00);
        peek(1'b1, r);
        chk("R10 status write ignored", r, 8'h12);
        #1 chk("R9 irq from dsr flag", irq, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule